// File: doc/BRIEF.md
# Two-Port Parallel I/O Adapter with Handshake Lines

This block is a memory-mapped parallel I/O peripheral with two identical 8-bit ports, A and B. Each port has a direction register, an output latch, a control register, one handshake input line (ctl1) and one handshake line (ctl2) that is either an input or an output. A CPU reaches four locations through a 2-bit register select. A chip select qualifies the single-cycle synchronous read and write strobes. The block watches the handshake lines for programmed edges, keeps two interrupt flags per port and drives one active-low interrupt line per port. It can also drive ctl2 as a programmed level or as an automatic strobe.

Port A and port B share one address between the direction register and the output latch. Control bit 2 picks which one is reached. Port accesses have side effects. Reading a port's output latch clears that port's flags. A read of port A fires a ctl2 strobe, and so does a write of port B. The ctl2 output of each port is driven by a four-state machine:
- `C2_IDLE_HI`: the line is high.
- `C2_PULSE_LO`: the line is low for a single cycle.
- `C2_WAIT_LO`: the line is low until a handshake edge.
- `C2_FORCE_LO`: the line is held low by a programmed level.

The state machine has these transitions, in order of priority:
- A control write takes it to `C2_FORCE_LO` in set/reset output mode with level bit 0. Any other control write takes it to `C2_IDLE_HI`.
- A strobe access takes it to `C2_PULSE_LO` when bit 3 is 1, or to `C2_WAIT_LO` when bit 3 is 0.
- `C2_PULSE_LO` moves to `C2_IDLE_HI` after one cycle.
- `C2_WAIT_LO` moves to `C2_IDLE_HI` on an active ctl1 edge.
- `C2_IDLE_HI` and `C2_FORCE_LO` hold.

Top module: `pio_adapter`

## Requirements
- R1: After reset, all registers are zero, so every pin is an input (dir 0x00). Both irq_n outputs are high, both ctl2 outputs are high and both ctl2 output enables are low.
- R2: Select 0 is the port A data location and select 1 is the port B data location. Select 2 is the port A control register and select 3 is the port B control register. When control bit 2 is 1, a data location reaches the output latch, and when it is 0 it reaches the direction register, for both reads and writes.
- R3: Reading a data location with bit 2 set returns the output latch on bits whose direction bit is 1, and the input pin on bits whose direction bit is 0.
- R4: A control read returns {ctl1 flag, ctl2 flag, bits 5..0}. A control write changes only bits 5..0 and never changes the flags.
- R5: An active ctl1 edge sets bit 7. The edge is rising when bit 1 is 1 and falling when bit 1 is 0. The opposite edge has no effect.
- R6: While bit 5 is 0 (ctl2 input), an active ctl2 edge sets bit 6. The edge is rising when bit 4 is 1 and falling when bit 4 is 0. While bit 5 is 1, bit 6 reads 0 and ctl2 edges do not set it.
- R7: irq_n is low exactly when (bit 7 and bit 0) or (bit 6 and bit 3 and not bit 5).
- R8: Reading a port's data location with bit 2 set clears both of that port's flags. Reading it with bit 2 clear (direction register) leaves them.
- R9: A control write with bits 5 and 4 both 1 drives ctl2 to the written bit 3 from the next cycle.
- R10: With bit 5 = 1, bit 4 = 0 and bit 3 = 1, reading the port A output latch drives ctl2 of port A low for exactly one cycle after the access.
- R11: With bit 5 = 1, bit 4 = 0 and bit 3 = 0, the strobe leaves ctl2 low until the next active ctl1 edge, and it is high from the cycle after that edge.
- R12: Port B strobes on writes to its output latch, not on reads. Its pulse and handshake restore options are the same as for port A.
- R13: A control write that does not select set/reset output mode returns ctl2 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select qualifying rd and wr |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| reg_sel | input | 2 | Location select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (zero when not reading) |
| a_pin_in | input | 8 | Port A pin sample |
| a_pin_out | output | 8 | Port A output latch |
| a_pin_dir | output | 8 | Port A direction (1 = output) |
| a_ctl1 | input | 1 | Port A handshake input |
| a_ctl2_in | input | 1 | Port A ctl2 input value |
| a_ctl2_out | output | 1 | Port A ctl2 driven value |
| a_ctl2_oe | output | 1 | Port A ctl2 output enable |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_pin_in | input | 8 | Port B pin sample |
| b_pin_out | output | 8 | Port B output latch |
| b_pin_dir | output | 8 | Port B direction (1 = output) |
| b_ctl1 | input | 1 | Port B handshake input |
| b_ctl2_in | input | 1 | Port B ctl2 input value |
| b_ctl2_out | output | 1 | Port B ctl2 driven value |
| b_ctl2_oe | output | 1 | Port B ctl2 output enable |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
Several rules hold on every cycle and are checked by properties:
- a pulse strobe lasts a single cycle;
- a handshake strobe stays low until a ctl1 edge;
- set/reset writes drive their level, and other control writes release the line;
- control writes leave the flags alone, and output-latch reads clear them;
- bit 6 is masked while ctl2 is an output.

Only the directed scenarios can show the rest: the address map, the bit-by-bit mixing of latch and pin on reads, which edge polarity counts, and the read-versus-write strobe difference between the ports.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
    // control register bit positions
    localparam int CB_C1_IE   = 0;  // ctl1 interrupt enable
    localparam int CB_C1_RISE = 1;  // ctl1 active edge: 1 rising, 0 falling
    localparam int CB_OL_SEL  = 2;  // data location: 1 output latch, 0 direction
    localparam int CB_C2_B3   = 3;  // ctl2 irq enable / level / pulse restore
    localparam int CB_C2_B4   = 4;  // ctl2 input edge / set-reset mode
    localparam int CB_C2_OUT  = 5;  // ctl2 is an output
    localparam int CB_FLAG2   = 6;
    localparam int CB_FLAG1   = 7;
    localparam int CTRL_W     = 8;
    localparam int CTRL_WR_W  = 6;

    typedef enum logic [1:0] {
        LOC_DATA_A = 2'd0,
        LOC_DATA_B = 2'd1,
        LOC_CTRL_A = 2'd2,
        LOC_CTRL_B = 2'd3
    } loc_e;

    typedef enum logic [1:0] {
        C2_IDLE_HI  = 2'd0,
        C2_PULSE_LO = 2'd1,
        C2_WAIT_LO  = 2'd2,
        C2_FORCE_LO = 2'd3
    } c2_state_e;
endpackage

// File: rtl/pio_edge_detect.sv
`timescale 1ns/1ps
module pio_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        if (!primed_q)
            hit = 1'b0;
        else if (rise_sel)
            hit = pin & ~prev_q;
        else
            hit = ~pin & prev_q;
    end
endmodule

// File: rtl/pio_c2_fsm.sv
`timescale 1ns/1ps
module pio_c2_fsm
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_out,
    input  logic cfg_sr,
    input  logic cfg_lvl,
    input  logic trig,
    input  logic pulse_mode,
    input  logic restore_hit,
    output logic c2_out
);
    c2_state_e state_q;
    c2_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d = (cfg_out && cfg_sr && !cfg_lvl) ? C2_FORCE_LO : C2_IDLE_HI;
        end else if (trig) begin
            state_d = pulse_mode ? C2_PULSE_LO : C2_WAIT_LO;
        end else begin
            unique case (state_q)
                C2_IDLE_HI:  state_d = C2_IDLE_HI;
                C2_PULSE_LO: state_d = C2_IDLE_HI;
                C2_WAIT_LO:  state_d = restore_hit ? C2_IDLE_HI : C2_WAIT_LO;
                C2_FORCE_LO: state_d = C2_FORCE_LO;
                default:     state_d = C2_IDLE_HI;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= C2_IDLE_HI;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            C2_IDLE_HI:  c2_out = 1'b1;
            C2_PULSE_LO: c2_out = 1'b0;
            C2_WAIT_LO:  c2_out = 1'b0;
            C2_FORCE_LO: c2_out = 1'b0;
            default:     c2_out = 1'b1;
        endcase
    end

    AST_SR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_out && cfg_sr) |=> (c2_out == $past(cfg_lvl))); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C2_PULSE_LO && !cfg_wr && !trig) |=> (state_q == C2_IDLE_HI)); // R10
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C2_WAIT_LO && !restore_hit && !cfg_wr) |=> !c2_out); // R11
    AST_CFG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !(cfg_out && cfg_sr)) |=> c2_out); // R13
endmodule

// File: rtl/pio_port.sv
`timescale 1ns/1ps
module pio_port
    import pio_pkg::*;
#(
    parameter int DW             = 8,
    parameter bit STROBE_ON_READ = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_data,
    input  logic          sel_ctrl,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_data,
    output logic [DW-1:0] rdata_ctrl,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_dir,
    input  logic          ctl1,
    input  logic          ctl2_in,
    output logic          ctl2_out,
    output logic          ctl2_oe,
    output logic          irq_n
);
    logic [DW-1:0]        dir_q;
    logic [DW-1:0]        latch_q;
    logic [CTRL_WR_W-1:0] ctrl_q;
    logic                 flag1_q;
    logic                 flag2_q;
    logic [CTRL_W-1:0]    ctrl_view;

    logic ol_sel, data_wr, data_rd, cfg_wr, latch_rd, latch_wr;
    logic c1_hit, c2_hit, strobe_src, strobe_trig;

    assign ol_sel   = ctrl_q[CB_OL_SEL];
    assign data_wr  = wr & sel_data;
    assign data_rd  = rd & sel_data;
    assign cfg_wr   = wr & sel_ctrl;
    assign latch_rd = data_rd & ol_sel;
    assign latch_wr = data_wr & ol_sel;

    pio_edge_detect u_c1_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ctl1),
        .rise_sel (ctrl_q[CB_C1_RISE]),
        .hit      (c1_hit)
    );

    pio_edge_detect u_c2_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ctl2_in),
        .rise_sel (ctrl_q[CB_C2_B4]),
        .hit      (c2_hit)
    );

    generate
        if (STROBE_ON_READ) begin : g_rd_strobe
            assign strobe_src = latch_rd;
        end else begin : g_wr_strobe
            assign strobe_src = latch_wr;
        end
    endgenerate

    assign strobe_trig = strobe_src & ctrl_q[CB_C2_OUT] & ~ctrl_q[CB_C2_B4];

    // data-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
        end else if (data_wr) begin
            if (ol_sel)
                latch_q <= wdata;
            else
                dir_q <= wdata;
        end
    end

    // control register and flags (an edge wins over a same-cycle clear)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            flag1_q <= 1'b0;
            flag2_q <= 1'b0;
        end else begin
            if (cfg_wr)
                ctrl_q <= wdata[CTRL_WR_W-1:0];

            if (c1_hit)
                flag1_q <= 1'b1;
            else if (latch_rd)
                flag1_q <= 1'b0;

            if (ctrl_q[CB_C2_OUT])
                flag2_q <= 1'b0;
            else if (c2_hit)
                flag2_q <= 1'b1;
            else if (latch_rd)
                flag2_q <= 1'b0;
        end
    end

    pio_c2_fsm u_c2_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_out     (wdata[CB_C2_OUT]),
        .cfg_sr      (wdata[CB_C2_B4]),
        .cfg_lvl     (wdata[CB_C2_B3]),
        .trig        (strobe_trig),
        .pulse_mode  (ctrl_q[CB_C2_B3]),
        .restore_hit (c1_hit),
        .c2_out      (ctl2_out)
    );

    always_comb begin
        ctrl_view                      = '0;
        ctrl_view[CTRL_WR_W-1:0]       = ctrl_q;
        ctrl_view[CB_FLAG2]            = flag2_q & ~ctrl_q[CB_C2_OUT];
        ctrl_view[CB_FLAG1]            = flag1_q;
    end

    assign rdata_ctrl = DW'(ctrl_view);
    assign rdata_data = ol_sel ? ((latch_q & dir_q) | (pin_in & ~dir_q)) : dir_q;
    assign pin_out    = latch_q;
    assign pin_dir    = dir_q;
    assign ctl2_oe    = ctrl_q[CB_C2_OUT];
    assign irq_n      = ~((flag1_q & ctrl_q[CB_C1_IE]) |
                          (flag2_q & ctrl_q[CB_C2_B3] & ~ctrl_q[CB_C2_OUT]));

    AST_FLAG_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rd && !c1_hit) |=> !flag1_q); // R8
    AST_DIR_READ_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !ol_sel && !c1_hit) |=> (flag1_q == $past(flag1_q))); // R8
    AST_CTRL_FLAGS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !c1_hit) |=> (flag1_q == $past(flag1_q))); // R4
    AST_C2_OUT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_C2_OUT] |=> !flag2_q); // R6
    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flag1_q || flag2_q)); // R7
endmodule

// File: rtl/pio_adapter.sv
`timescale 1ns/1ps
module pio_adapter
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] a_pin_in,
    output logic [DW-1:0] a_pin_out,
    output logic [DW-1:0] a_pin_dir,
    input  logic          a_ctl1,
    input  logic          a_ctl2_in,
    output logic          a_ctl2_out,
    output logic          a_ctl2_oe,
    output logic          a_irq_n,
    input  logic [DW-1:0] b_pin_in,
    output logic [DW-1:0] b_pin_out,
    output logic [DW-1:0] b_pin_dir,
    input  logic          b_ctl1,
    input  logic          b_ctl2_in,
    output logic          b_ctl2_out,
    output logic          b_ctl2_oe,
    output logic          b_irq_n
);
    logic          rd_q, wr_q;
    logic          a_sel_data, a_sel_ctrl, b_sel_data, b_sel_ctrl;
    logic [DW-1:0] a_rd_data, a_rd_ctrl, b_rd_data, b_rd_ctrl;

    assign rd_q = cs & rd;
    assign wr_q = cs & wr;

    assign a_sel_data = (loc_e'(reg_sel) == LOC_DATA_A);
    assign b_sel_data = (loc_e'(reg_sel) == LOC_DATA_B);
    assign a_sel_ctrl = (loc_e'(reg_sel) == LOC_CTRL_A);
    assign b_sel_ctrl = (loc_e'(reg_sel) == LOC_CTRL_B);

    pio_port #(.DW(DW), .STROBE_ON_READ(1'b1)) u_port_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_data   (a_sel_data),
        .sel_ctrl   (a_sel_ctrl),
        .rd         (rd_q),
        .wr         (wr_q),
        .wdata      (wdata),
        .rdata_data (a_rd_data),
        .rdata_ctrl (a_rd_ctrl),
        .pin_in     (a_pin_in),
        .pin_out    (a_pin_out),
        .pin_dir    (a_pin_dir),
        .ctl1       (a_ctl1),
        .ctl2_in    (a_ctl2_in),
        .ctl2_out   (a_ctl2_out),
        .ctl2_oe    (a_ctl2_oe),
        .irq_n      (a_irq_n)
    );

    pio_port #(.DW(DW), .STROBE_ON_READ(1'b0)) u_port_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_data   (b_sel_data),
        .sel_ctrl   (b_sel_ctrl),
        .rd         (rd_q),
        .wr         (wr_q),
        .wdata      (wdata),
        .rdata_data (b_rd_data),
        .rdata_ctrl (b_rd_ctrl),
        .pin_in     (b_pin_in),
        .pin_out    (b_pin_out),
        .pin_dir    (b_pin_dir),
        .ctl1       (b_ctl1),
        .ctl2_in    (b_ctl2_in),
        .ctl2_out   (b_ctl2_out),
        .ctl2_oe    (b_ctl2_oe),
        .irq_n      (b_irq_n)
    );

    always_comb begin
        rdata = '0;
        if (rd_q) begin
            unique case (loc_e'(reg_sel))
                LOC_DATA_A: rdata = a_rd_data;
                LOC_DATA_B: rdata = b_rd_data;
                LOC_CTRL_A: rdata = a_rd_ctrl;
                LOC_CTRL_B: rdata = b_rd_ctrl;
                default:    rdata = '0;
            endcase
        end
    end

    AST_CTRL_A_BIT6_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && reg_sel == 2'd2 && a_ctl2_oe) |-> (rdata[CB_FLAG2] == 1'b0)); // R6
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_q |-> (rdata == '0)); // R2
endmodule

// File: tb/tb_pio_adapter.sv
`timescale 1ns/1ps
module tb_pio_adapter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] a_pin_in = 8'h00, b_pin_in = 8'h00;
    logic [7:0] a_pin_out, a_pin_dir, b_pin_out, b_pin_dir;
    logic       a_ctl1 = 1'b0, a_ctl2_in = 1'b0, b_ctl1 = 1'b0, b_ctl2_in = 1'b0;
    logic       a_ctl2_out, a_ctl2_oe, a_irq_n, b_ctl2_out, b_ctl2_oe, b_irq_n;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    pio_adapter dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
        .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_dir(a_pin_dir),
        .a_ctl1(a_ctl1), .a_ctl2_in(a_ctl2_in), .a_ctl2_out(a_ctl2_out),
        .a_ctl2_oe(a_ctl2_oe), .a_irq_n(a_irq_n),
        .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_dir(b_pin_dir),
        .b_ctl1(b_ctl1), .b_ctl2_in(b_ctl2_in), .b_ctl2_out(b_ctl2_out),
        .b_ctl2_oe(b_ctl2_oe), .b_irq_n(b_irq_n)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; reg_sel = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; reg_sel = a;
        #2 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1", "a_irq_n", {7'd0, a_irq_n}, 8'h01);
        check("R1", "b_irq_n", {7'd0, b_irq_n}, 8'h01);
        check("R1", "a_ctl2_out", {7'd0, a_ctl2_out}, 8'h01);
        check("R1", "b_ctl2_out", {7'd0, b_ctl2_out}, 8'h01);
        check("R1", "ctl2 oe", {6'd0, a_ctl2_oe, b_ctl2_oe}, 8'h00);
        check("R1", "a_pin_dir", a_pin_dir, 8'h00);
        check("R1", "b_pin_dir", b_pin_dir, 8'h00);
        for (int i = 0; i < 4; i++) begin
            bus_read(2'(i), v);
            check("R1", "reset location", v, 8'h00);
        end
    endtask

    task automatic t_port_access();
        logic [7:0] v;
        bus_write(2'd0, 8'hF0);
        bus_read(2'd0, v);
        check("R2", "A direction readback", v, 8'hF0);
        check("R2", "A direction pins", a_pin_dir, 8'hF0);
        bus_read(2'd1, v);
        check("R2", "B direction untouched", v, 8'h00);
        bus_write(2'd2, 8'h04);
        bus_write(2'd0, 8'h5A);
        check("R2", "A latch written", a_pin_out, 8'h5A);
        check("R2", "A direction kept", a_pin_dir, 8'hF0);
        a_pin_in = 8'h3C;
        bus_read(2'd0, v);
        check("R3", "A mixed read", v, 8'h5C);
        bus_read(2'd2, v);
        check("R4", "A control readback", v, 8'h04);
    endtask

    task automatic t_ctrl_ro();
        logic [7:0] v;
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, v);
        check("R4", "B control bits 7,6 ignored", v, 8'h3F);
        check("R9", "B ctl2 set high", {7'd0, b_ctl2_out}, 8'h01);
        check("R9", "B ctl2 oe", {7'd0, b_ctl2_oe}, 8'h01);
        bus_write(2'd3, 8'h30);
        check("R9", "B ctl2 set low", {7'd0, b_ctl2_out}, 8'h00);
        bus_write(2'd3, 8'h38);
        check("R9", "B ctl2 set high again", {7'd0, b_ctl2_out}, 8'h01);
        bus_write(2'd3, 8'h00);
    endtask

    task automatic t_c1_edges();
        logic [7:0] v;
        bus_write(2'd2, 8'h07);
        a_ctl1 = 1'b1; idle(1);
        check("R7", "A irq on ctl1 rise", {7'd0, a_irq_n}, 8'h00);
        bus_read(2'd2, v);
        check("R5", "A flag1 on rise", v, 8'h87);
        bus_read(2'd0, v);
        check("R8", "A irq cleared by latch read", {7'd0, a_irq_n}, 8'h01);
        bus_read(2'd2, v);
        check("R8", "A flag1 cleared", v, 8'h07);
        a_ctl1 = 1'b0; idle(1);
        bus_read(2'd2, v);
        check("R5", "A falling edge ignored", v, 8'h07);
        bus_write(2'd2, 8'h05);
        a_ctl1 = 1'b1; idle(1);
        bus_read(2'd2, v);
        check("R5", "A rising ignored in falling mode", v, 8'h05);
        a_ctl1 = 1'b0; idle(1);
        bus_read(2'd2, v);
        check("R5", "A flag1 on fall", v, 8'h85);
        bus_write(2'd2, 8'h01);
        bus_read(2'd2, v);
        check("R4", "control write keeps flag", v, 8'h81);
        bus_read(2'd0, v);
        bus_read(2'd2, v);
        check("R8", "direction read keeps flag", v, 8'h81);
        bus_write(2'd2, 8'h05);
        bus_read(2'd0, v);
        bus_read(2'd2, v);
        check("R8", "flag cleared again", v, 8'h05);
    endtask

    task automatic t_c2_input();
        logic [7:0] v;
        bus_write(2'd2, 8'h1C);
        a_ctl2_in = 1'b1; idle(1);
        check("R7", "A irq on ctl2 edge", {7'd0, a_irq_n}, 8'h00);
        bus_read(2'd2, v);
        check("R6", "A flag2 on rise", v, 8'h5C);
        bus_read(2'd0, v);
        bus_read(2'd2, v);
        check("R8", "A flag2 cleared", v, 8'h1C);
        a_ctl2_in = 1'b0; idle(1);
        bus_read(2'd2, v);
        check("R6", "A ctl2 fall ignored", v, 8'h1C);
        bus_write(2'd2, 8'h3C);
        check("R9", "A ctl2 level high", {7'd0, a_ctl2_out}, 8'h01);
        a_ctl2_in = 1'b1; idle(1);
        bus_read(2'd2, v);
        check("R6", "A flag2 blocked as output", v, 8'h3C);
        check("R7", "A irq stays high", {7'd0, a_irq_n}, 8'h01);
        a_ctl2_in = 1'b0;
        bus_write(2'd2, 8'h34);
        check("R9", "A ctl2 level low", {7'd0, a_ctl2_out}, 8'h00);
    endtask

    task automatic t_strobe_a();
        logic [7:0] v;
        bus_write(2'd2, 8'h2C);
        check("R13", "A ctl2 released", {7'd0, a_ctl2_out}, 8'h01);
        bus_read(2'd0, v);
        check("R10", "A pulse low", {7'd0, a_ctl2_out}, 8'h00);
        idle(1);
        check("R10", "A pulse restored", {7'd0, a_ctl2_out}, 8'h01);
        bus_write(2'd2, 8'h26);
        bus_read(2'd0, v);
        check("R11", "A handshake low", {7'd0, a_ctl2_out}, 8'h00);
        idle(3);
        check("R11", "A handshake held", {7'd0, a_ctl2_out}, 8'h00);
        a_ctl1 = 1'b1; idle(1);
        check("R11", "A handshake restored", {7'd0, a_ctl2_out}, 8'h01);
        bus_read(2'd2, v);
        check("R11", "A flag1 from restore edge", v, 8'hA6);
        a_ctl1 = 1'b0;
    endtask

    task automatic t_strobe_b();
        logic [7:0] v;
        bus_write(2'd3, 8'h2C);
        bus_write(2'd1, 8'h77);
        check("R12", "B write strobe low", {7'd0, b_ctl2_out}, 8'h00);
        check("R12", "B latch", b_pin_out, 8'h77);
        idle(1);
        check("R12", "B pulse restored", {7'd0, b_ctl2_out}, 8'h01);
        bus_read(2'd1, v);
        check("R12", "B read no strobe", {7'd0, b_ctl2_out}, 8'h01);
        bus_write(2'd3, 8'h26);
        bus_write(2'd1, 8'h11);
        idle(2);
        check("R12", "B handshake held", {7'd0, b_ctl2_out}, 8'h00);
        b_ctl1 = 1'b1; idle(1);
        check("R12", "B handshake restored", {7'd0, b_ctl2_out}, 8'h01);
        bus_write(2'd3, 8'h30);
        check("R9", "B forced low", {7'd0, b_ctl2_out}, 8'h00);
        bus_write(2'd3, 8'h24);
        check("R13", "B released by strobe config", {7'd0, b_ctl2_out}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_port_access();
        t_ctrl_ro();
        t_c1_edges();
        t_c2_input();
        t_strobe_a();
        t_strobe_b();
        idle(2);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule